// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits at the root of an error-reporting hierarchy. It accepts one error message per cycle, each carrying a severity and a 16-bit requester ID. From these it keeps a root error status register that records which categories of error have arrived, whether more than one of a kind has arrived, and whether the first uncorrectable error was fatal. A source register captures the ID of the first correctable and the first uncorrectable requester.

A three-bit command register, written by software, selects which pending categories may raise an interrupt. In level mode the block drives an interrupt line equal to the OR of the enabled pending categories. In message mode it instead emits a one-cycle pulse carrying the interrupt vector number. The pulse fires only when the set of enabled pending categories goes from empty to non-empty. Software clears report bits by writing ones to them. The vector field of the status register follows a hardware input and cannot be written.

Top module: `root_err_collector`

## Requirements
- R1: A correctable message (msg_sev=0) sets status bit 0. If bit 0 was already set, bit 1 (multiple correctable) is set instead of storing the ID; otherwise msg_src is stored in err_src[15:0].
- R2: A non-fatal message (msg_sev=1) sets status bit 5.
- R3: A fatal message (msg_sev=2) sets status bit 6, and sets bit 4 (first uncorrectable was fatal) only if bit 2 was clear before the message.
- R4: A non-fatal or fatal message sets status bit 2. If bit 2 was already set, bit 3 (multiple uncorrectable) is set; otherwise msg_src is stored in err_src[31:16]. err_src changes only through R1 and R4.
- R5: A message with msg_sev=3 has no effect on status, source or interrupts.
- R6: When sts_wr is high, each one in sts_wdata[6:0] clears that status bit. All other written bits are ignored. Status bits 31:27 always show the msg_vec value of the previous cycle, and bits 26:7 read zero.
- R7: When a status write and a message fall in the same cycle, the clear is applied first and the message second, so the message's effect is never lost.
- R8: After reset, root_cmd, status, err_src and both interrupt outputs are zero. A cmd_wr loads root_cmd from cmd_wdata. Bit 0 enables correctable, bit 1 non-fatal and bit 2 fatal.
- R9: In level mode (msg_mode=0), intx_level equals the OR of root_cmd ANDed with the pending categories {bit6, bit5, bit0}, as both stand after the update. In this mode msg_irq is never raised.
- R10: In message mode, msg_irq pulses for one cycle with msg_irq_vec equal to the new vector field. This happens only when the enabled pending set before the update is empty and the enabled pending set after the update is not. The "before" set uses the old command and the status after any same-cycle clear. In this mode intx_level stays low.
- R11: All outputs are registered and reflect inputs sampled at the preceding rising edge of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Error message present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 none |
| msg_src | input | 16 | Requester ID of the message |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 3 | Command write data (enables) |
| sts_wr | input | 1 | Status write strobe (write-1-to-clear) |
| sts_wdata | input | 32 | Status write data |
| msg_mode | input | 1 | 1 selects message interrupts, 0 level interrupt |
| msg_vec | input | 5 | Interrupt vector number supplied by hardware |
| root_cmd | output | 3 | Command register |
| root_sts | output | 32 | Root error status register |
| err_src | output | 32 | Error source IDs: uncorrectable high, correctable low |
| intx_level | output | 1 | Level interrupt |
| msg_irq | output | 1 | One-cycle message interrupt pulse |
| msg_irq_vec | output | 5 | Vector number carried by the pulse |

## Verification
A message can arrive in the same cycle as a status clear. A message can also arrive in the same cycle as a command write. Both cases are steered directly. The first is checked with a clear of a bit that the message then sets again, where the multiple flag must stay clear. The second is checked with an enable written as its category becomes pending, where exactly one message pulse must appear. A long stretch of random traffic then mixes both collisions freely. Every cycle is judged against a behavioural model that applies the clear first, then the message, then compares enabled pending sets before and after.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_NONE     = 2'd3
  } sev_e;

  localparam int RPT_W  = 7;
  localparam int CMD_W  = 3;
  localparam int B_COR  = 0;
  localparam int B_MCOR = 1;
  localparam int B_UNC  = 2;
  localparam int B_MUNC = 3;
  localparam int B_FFAT = 4;
  localparam int B_NF   = 5;
  localparam int B_FAT  = 6;

  // pending categories aligned with command enable bits {fatal, nonfatal, cor}
  function automatic logic [CMD_W-1:0] pend_cats(input logic [RPT_W-1:0] s);
    return {s[B_FAT], s[B_NF], s[B_COR]};
  endfunction
endpackage

// File: rtl/rpe_status_unit.sv
module rpe_status_unit
  import rpe_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_en,
  input  logic [RPT_W-1:0]     clr_bits,
  input  logic                 msg_valid,
  input  logic [1:0]           msg_sev,
  input  logic [SRC_W-1:0]     msg_src,
  output logic [RPT_W-1:0]     rpt_q,
  output logic [RPT_W-1:0]     rpt_cleared,
  output logic [RPT_W-1:0]     rpt_next,
  output logic [2*SRC_W-1:0]   src_q
);
  logic [2*SRC_W-1:0] src_next;
  logic               is_uncor;

  always_comb begin
    rpt_cleared = rpt_q & ~(clr_en ? clr_bits : '0);
    rpt_next    = rpt_cleared;
    src_next    = src_q;
    is_uncor    = msg_valid && (msg_sev == SEV_NONFATAL || msg_sev == SEV_FATAL);
    if (msg_valid) begin
      unique case (sev_e'(msg_sev))
        SEV_COR: begin
          if (rpt_cleared[B_COR]) rpt_next[B_MCOR] = 1'b1;
          else                    src_next[SRC_W-1:0] = msg_src;
          rpt_next[B_COR] = 1'b1;
        end
        SEV_NONFATAL: rpt_next[B_NF] = 1'b1;
        SEV_FATAL: begin
          if (!rpt_cleared[B_UNC]) rpt_next[B_FFAT] = 1'b1;
          rpt_next[B_FAT] = 1'b1;
        end
        default: ;
      endcase
    end
    if (is_uncor) begin
      if (rpt_cleared[B_UNC]) rpt_next[B_MUNC] = 1'b1;
      else                    src_next[2*SRC_W-1:SRC_W] = msg_src;
      rpt_next[B_UNC] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_q <= '0;
      src_q <= '0;
    end else begin
      rpt_q <= rpt_next;
      src_q <= src_next;
    end
  end
endmodule

// File: rtl/rpe_irq_unit.sv
module rpe_irq_unit
  import rpe_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_mode,
  input  logic [CMD_W-1:0] cmd_cur,
  input  logic [CMD_W-1:0] cmd_nxt,
  input  logic [CMD_W-1:0] cat_before,
  input  logic [CMD_W-1:0] cat_after,
  input  logic [VEC_W-1:0] vec_nxt,
  output logic             intx_q,
  output logic             pulse_q,
  output logic [VEC_W-1:0] pvec_q
);
  logic en_before, en_after;

  assign en_before = |(cmd_cur & cat_before);
  assign en_after  = |(cmd_nxt & cat_after);

  always_ff @(posedge clk) begin
    if (rst) begin
      intx_q  <= 1'b0;
      pulse_q <= 1'b0;
      pvec_q  <= '0;
    end else begin
      intx_q  <= !msg_mode && en_after;
      pulse_q <= msg_mode && en_after && !en_before;
      pvec_q  <= vec_nxt;
    end
  end
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rpe_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5,
  parameter int STS_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_valid,
  input  logic [1:0]         msg_sev,
  input  logic [SRC_W-1:0]   msg_src,
  input  logic               cmd_wr,
  input  logic [2:0]         cmd_wdata,
  input  logic               sts_wr,
  input  logic [STS_W-1:0]   sts_wdata,
  input  logic               msg_mode,
  input  logic [VEC_W-1:0]   msg_vec,
  output logic [2:0]         root_cmd,
  output logic [STS_W-1:0]   root_sts,
  output logic [2*SRC_W-1:0] err_src,
  output logic               intx_level,
  output logic               msg_irq,
  output logic [VEC_W-1:0]   msg_irq_vec
);
  localparam int PAD_W = STS_W - VEC_W - RPT_W;

  logic [CMD_W-1:0] cmd_q, cmd_next;
  logic [VEC_W-1:0] vec_q;
  logic [RPT_W-1:0] rpt_q, rpt_cleared, rpt_next;

  assign cmd_next = cmd_wr ? cmd_wdata : cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      vec_q <= '0;
    end else begin
      cmd_q <= cmd_next;
      vec_q <= msg_vec;
    end
  end

  rpe_status_unit #(.SRC_W(SRC_W)) u_sts (
    .clk        (clk),
    .rst        (rst),
    .clr_en     (sts_wr),
    .clr_bits   (sts_wdata[RPT_W-1:0]),
    .msg_valid  (msg_valid),
    .msg_sev    (msg_sev),
    .msg_src    (msg_src),
    .rpt_q      (rpt_q),
    .rpt_cleared(rpt_cleared),
    .rpt_next   (rpt_next),
    .src_q      (err_src)
  );

  rpe_irq_unit #(.VEC_W(VEC_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .msg_mode  (msg_mode),
    .cmd_cur   (cmd_q),
    .cmd_nxt   (cmd_next),
    .cat_before(pend_cats(rpt_cleared)),
    .cat_after (pend_cats(rpt_next)),
    .vec_nxt   (msg_vec),
    .intx_q    (intx_level),
    .pulse_q   (msg_irq),
    .pvec_q    (msg_irq_vec)
  );

  assign root_cmd = cmd_q;
  assign root_sts = {vec_q, {PAD_W{1'b0}}, rpt_q};
endmodule

// File: rtl/rpe_checker.sv
module rpe_checker #(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5,
  parameter int STS_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               msg_valid,
  input logic [1:0]         msg_sev,
  input logic               cmd_wr,
  input logic               sts_wr,
  input logic               msg_mode,
  input logic [VEC_W-1:0]   msg_vec,
  input logic [2:0]         root_cmd,
  input logic [STS_W-1:0]   root_sts,
  input logic [2*SRC_W-1:0] err_src,
  input logic               intx_level,
  input logic               msg_irq
);
  a_r10_pulse_needs_enabled_pending: assert property (@(posedge clk) disable iff (rst)
    msg_irq |-> |(root_cmd & {root_sts[6], root_sts[5], root_sts[0]}));

  a_r9_pulse_only_in_msg_mode: assert property (@(posedge clk) disable iff (rst)
    (msg_irq && !$past(rst)) |-> $past(msg_mode));

  a_r10_no_level_in_msg_mode: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(msg_mode)) |-> !intx_level);

  a_r6_vector_tracks_input: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> root_sts[STS_W-1 -: VEC_W] == $past(msg_vec));

  a_r4_src_only_on_message: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(msg_valid)) |-> $stable(err_src));

  a_r8_cmd_holds_without_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cmd_wr)) |-> $stable(root_cmd));

  a_r5_none_severity_inert: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(msg_valid) && $past(msg_sev) == 2'd3 && !$past(sts_wr))
      |-> ($stable(root_sts[6:0]) && $stable(err_src)));
endmodule

bind root_err_collector rpe_checker #(.SRC_W(SRC_W), .VEC_W(VEC_W), .STS_W(STS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_valid (msg_valid),
  .msg_sev   (msg_sev),
  .cmd_wr    (cmd_wr),
  .sts_wr    (sts_wr),
  .msg_mode  (msg_mode),
  .msg_vec   (msg_vec),
  .root_cmd  (root_cmd),
  .root_sts  (root_sts),
  .err_src   (err_src),
  .intx_level(intx_level),
  .msg_irq   (msg_irq)
);

// File: tb/sim_root_err_collector.sv
`timescale 1ns/1ps
module sim_root_err_collector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_valid = 1'b0;
  logic [1:0] msg_sev = 2'd3;
  logic [15:0] msg_src = '0;
  logic cmd_wr = 1'b0;
  logic [2:0] cmd_wdata = '0;
  logic sts_wr = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic msg_mode = 1'b0;
  logic [4:0] msg_vec = '0;
  logic [2:0] root_cmd;
  logic [31:0] root_sts;
  logic [31:0] err_src;
  logic intx_level, msg_irq;
  logic [4:0] msg_irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [6:0]  m_rpt = '0;
  logic [31:0] m_src = '0;
  logic [2:0]  m_cmd = '0;
  logic [4:0]  m_vec = '0;
  logic        m_intx = 1'b0;
  logic        m_pulse = 1'b0;
  logic [4:0]  m_pvec = '0;

  always #2 clk = ~clk;

  root_err_collector u0 (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .msg_mode(msg_mode), .msg_vec(msg_vec), .root_cmd(root_cmd), .root_sts(root_sts),
    .err_src(err_src), .intx_level(intx_level), .msg_irq(msg_irq), .msg_irq_vec(msg_irq_vec)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] es;
    es = {m_vec, 20'h0, m_rpt};
    check(root_sts === es, "status (R1 R2 R3 R4 R5 R6 R7)", root_sts, es);
    check(err_src === m_src, "source (R1 R4)", err_src, m_src);
    check(root_cmd === m_cmd, "command (R8)", {29'h0, root_cmd}, {29'h0, m_cmd});
    check(intx_level === m_intx, "level irq (R9 R11)", {31'h0, intx_level}, {31'h0, m_intx});
    check(msg_irq === m_pulse, "msg irq (R10 R11)", {31'h0, msg_irq}, {31'h0, m_pulse});
    if (m_pulse)
      check(msg_irq_vec === m_pvec, "msg irq vector (R10)", {27'h0, msg_irq_vec}, {27'h0, m_pvec});
  endtask

  task automatic step(input logic v, input logic [1:0] sv, input logic [15:0] id,
                      input logic cw, input logic [2:0] cd, input logic sw,
                      input logic [31:0] sd, input logic md, input logic [4:0] vc);
    logic [6:0] r;
    logic [2:0] ncmd;
    bit had, now;
    msg_valid = v; msg_sev = sv; msg_src = id; cmd_wr = cw; cmd_wdata = cd;
    sts_wr = sw; sts_wdata = sd; msg_mode = md; msg_vec = vc;
    r = m_rpt;
    if (sw) r = r & ~sd[6:0];
    had = ((m_cmd[0] && r[0]) || (m_cmd[1] && r[5]) || (m_cmd[2] && r[6]));
    if (v && sv == 2'd0) begin
      if (r[0]) r[1] = 1'b1; else m_src[15:0] = id;
      r[0] = 1'b1;
    end
    if (v && (sv == 2'd1 || sv == 2'd2)) begin
      if (sv == 2'd2) begin
        if (!r[2]) r[4] = 1'b1;
        r[6] = 1'b1;
      end else r[5] = 1'b1;
      if (r[2]) r[3] = 1'b1; else m_src[31:16] = id;
      r[2] = 1'b1;
    end
    ncmd = cw ? cd : m_cmd;
    now = ((ncmd[0] && r[0]) || (ncmd[1] && r[5]) || (ncmd[2] && r[6]));
    m_rpt = r; m_cmd = ncmd; m_vec = vc;
    m_intx = !md && now;
    m_pulse = md && now && !had;
    m_pvec = vc;
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle(input logic md, input logic [4:0] vc);
    step(1'b0, 2'd3, 16'h0, 1'b0, 3'd0, 1'b0, 32'h0, md, vc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired (R11) actual=%h expected=%h", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check(root_sts === 32'h0 && err_src === 32'h0 && root_cmd === 3'h0, "reset state (R8)",
          root_sts | err_src, 32'h0);
    check(!intx_level && !msg_irq, "reset irq (R8)", {30'h0, intx_level, msg_irq}, 32'h0);
    rst = 1'b0;

    // R1 first and repeated correctable, level mode, no enable
    step(1, 2'd0, 16'h1234, 0, 3'd0, 0, 32'h0, 0, 5'd0);
    check(err_src[15:0] === 16'h1234 && root_sts[0], "first correctable ID (R1)", err_src, 32'h1234);
    step(1, 2'd0, 16'h5555, 0, 3'd0, 0, 32'h0, 0, 5'd0);
    check(root_sts[1:0] === 2'b11 && err_src[15:0] === 16'h1234, "multiple correctable (R1)", root_sts, 32'h3);
    // R9 enable correctable gives level, clearing drops it
    step(0, 2'd3, 16'h0, 1, 3'b001, 0, 32'h0, 0, 5'd0);
    check(intx_level === 1'b1, "level on enable (R9)", {31'h0, intx_level}, 32'h1);
    step(0, 2'd3, 16'h0, 0, 3'd0, 1, 32'h3, 0, 5'd0);
    check(intx_level === 1'b0 && root_sts[1:0] == 2'b00, "level drops after clear (R6 R9)", root_sts, 32'h0);
    // R2 R4 non-fatal then R3 fatal (not first)
    step(1, 2'd1, 16'hAAAA, 0, 3'd0, 0, 32'h0, 0, 5'd0);
    check(root_sts[6:0] === 7'b0100100 && err_src[31:16] === 16'hAAAA, "non-fatal (R2 R4)", root_sts, 32'h24);
    step(1, 2'd2, 16'hBBBB, 0, 3'd0, 0, 32'h0, 0, 5'd0);
    check(root_sts[6:0] === 7'b1101100 && err_src[31:16] === 16'hAAAA, "fatal after non-fatal (R3 R4)", root_sts, 32'h6C);
    // R3 first fatal
    step(0, 2'd3, 16'h0, 0, 3'd0, 1, 32'h7F, 0, 5'd0);
    step(1, 2'd2, 16'hC0DE, 0, 3'd0, 0, 32'h0, 0, 5'd0);
    check(root_sts[6:0] === 7'b1010100 && err_src[31:16] === 16'hC0DE, "first fatal (R3)", root_sts, 32'h54);
    // R5 none severity
    step(1, 2'd3, 16'hFFFF, 0, 3'd0, 0, 32'h0, 0, 5'd0);
    check(root_sts[6:0] === 7'b1010100 && err_src[31:16] === 16'hC0DE, "sev 3 ignored (R5)", root_sts, 32'h54);
    // R7 clear and message in one cycle
    step(0, 2'd3, 16'h0, 0, 3'd0, 1, 32'h7F, 0, 5'd0);
    step(1, 2'd0, 16'h0001, 0, 3'd0, 0, 32'h0, 0, 5'd0);
    step(1, 2'd0, 16'h0777, 0, 3'd0, 1, 32'h1, 0, 5'd0);
    check(root_sts[1:0] === 2'b01 && err_src[15:0] === 16'h0777, "clear before message (R7)", root_sts, 32'h1);
    // R6 non-report bits not writable, vector follows input
    step(0, 2'd3, 16'h0, 0, 3'd0, 1, 32'hFFFF_FF80, 0, 5'd21);
    check(root_sts === {5'd21, 20'h0, 7'h01}, "vector and pad (R6)", root_sts, {5'd21, 20'h0, 7'h01});

    // R10 message mode
    step(0, 2'd3, 16'h0, 1, 3'b000, 1, 32'h7F, 1, 5'd9);
    step(1, 2'd1, 16'h0100, 1, 3'b010, 0, 32'h0, 1, 5'd9);
    check(msg_irq === 1'b1 && msg_irq_vec === 5'd9, "pulse on enable with message (R10)", {31'h0, msg_irq}, 32'h1);
    step(1, 2'd1, 16'h0101, 0, 3'd0, 0, 32'h0, 1, 5'd9);
    check(msg_irq === 1'b0, "no repeat pulse (R10)", {31'h0, msg_irq}, 32'h0);
    step(0, 2'd3, 16'h0, 1, 3'b000, 1, 32'h7F, 1, 5'd3);
    step(1, 2'd0, 16'h0200, 0, 3'd0, 0, 32'h0, 1, 5'd3);
    check(msg_irq === 1'b0, "disabled category silent (R10)", {31'h0, msg_irq}, 32'h0);
    step(0, 2'd3, 16'h0, 1, 3'b001, 0, 32'h0, 1, 5'd4);
    check(msg_irq === 1'b1 && msg_irq_vec === 5'd4 && !intx_level, "pulse on command write (R10)", {31'h0, msg_irq}, 32'h1);
    step(0, 2'd3, 16'h0, 1, 3'b011, 0, 32'h0, 1, 5'd4);
    check(msg_irq === 1'b0, "already enabled, no pulse (R10)", {31'h0, msg_irq}, 32'h0);
    step(0, 2'd3, 16'h0, 1, 3'b100, 0, 32'h0, 1, 5'd4);
    check(msg_irq === 1'b0 && root_cmd === 3'b100, "enable of idle category (R8 R10)", {29'h0, root_cmd}, 32'h4);

    // random traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 1), 2'($urandom_range(0, 3)), 16'($urandom),
           ($urandom_range(0, 5) == 0), 3'($urandom), ($urandom_range(0, 5) == 0),
           $urandom, ((i / 500) % 2 == 1), 5'($urandom));
    end
    idle(0, 5'd0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule